// File: doc/BRIEF.md
# Compare, Bit-Test and Status Flag Unit

This block holds the four status flags of a small 8-bit datapath: zero (ZF), carry (CF), overflow (OF) and equal (EF). There is no negative flag. On each flags-load strobe it takes a 4-bit operation code. The code decides which flag sources may write which flags. Sources not enabled for the current code are discarded, and every flag without an enabled source keeps its value.

Two of the sources are inside the block. The value comparator checks the data bus either against zero or against the temp register. In the temp compare, OF means "temp is greater than bus", using unsigned magnitude. The bit tester picks one bus bit, indexed by the low bits of temp, and reports whether that bit is clear. The zero, carry and overflow results of the arithmetic unit and the carry out of the shifter arrive as plain inputs. When the flag output enable is high, the flag register drives its contents onto the data bus as a byte.

Every pin is a plain level control or status signal sampled on the rising clock edge. None of them carries a data stream, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `flag_unit`

## Requirements
- R1: While `rst_n` is low, all four flags clear to 0. `bus_out` reads 0 while `flag_out_en` is low.
- R2: When `flag_load` is low at a rising edge, no flag changes, whatever the other inputs are.
- R3: Code `op_sel`=4'b1111 with `cmp_sel`=1 (temp compare) sets EF to (bus_in == temp) and OF to (temp > bus_in, unsigned). ZF and CF are unchanged.
- R4: Code 4'b1111 with `cmp_sel`=0 (zero test) sets ZF to (bus_in == 0). CF, OF and EF are unchanged.
- R5: Code 4'b1000 (bit test) sets ZF to the inverse of `bus_in[temp[2:0]]`. The upper bits of temp do not affect the result, and CF, OF and EF are unchanged.
- R6: Codes 4'b0011 (add) and 4'b0010 (subtract) load ZF, CF and OF from `alu_zero`, `alu_carry` and `alu_ovf`. EF is unchanged.
- R7: Codes 4'b0110, 4'b0101 and 4'b0100 (logic operations) load ZF from `alu_zero` only. CF, OF and EF are unchanged, and the ALU carry and overflow inputs are ignored.
- R8: Codes 4'b1010 and 4'b1001 (shifts) load CF from `shift_carry` only. All other flags are unchanged.
- R9: Codes 4'b1110 and 4'b1101 (rotates), and every code not listed above, change no flag.
- R10: While `flag_out_en` is high, `bus_out` carries the flag byte: bit0=ZF, bit1=CF, bit2=OF, bit3=EF, bits 7..4 = 0. `bus_out_en` is high. While `flag_out_en` is low, `bus_out` is 0 and `bus_out_en` is low.
- R11: Op code bit 0 corresponds to control bit S0 and bit 3 to S3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation code, bit0 = S0 |
| cmp_sel | input | 1 | Under code 1111: 1 = compare with temp, 0 = test for zero |
| flag_load | input | 1 | Flags-load strobe |
| bus_in | input | 8 | Data bus value under test |
| temp | input | 8 | Temp register value |
| alu_zero | input | 1 | ALU zero result |
| alu_carry | input | 1 | ALU carry / no-borrow result |
| alu_ovf | input | 1 | ALU signed overflow result |
| shift_carry | input | 1 | Bit shifted out by the shifter |
| flag_out_en | input | 1 | Drive the flag byte onto the bus |
| bus_out | output | 8 | Flag byte, or 0 when not driven |
| bus_out_en | output | 1 | Bus drive enable |

## Verification
A wrong source-enable decode appears on the bus byte one edge after the load. The symptom is a flag that moved when it should have held, or one that held when it should have moved. Both a correct flag register and a faulty one accumulate history, so a single bad update stays visible on every later read until that flag is written again. For this reason the bench reads the flag byte after every edge. A swapped comparator sense or a bad bit index shows up in OF, EF or ZF on the read directly after the offending load.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

  localparam int FLAG_N = 4;
  localparam int SRC_N  = 3;

  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FO = 2;
  localparam int FE = 3;

  // op code bit 0 is S0 (R11)
  localparam logic [3:0] OP_ADD = 4'b0011;
  localparam logic [3:0] OP_SUB = 4'b0010;
  localparam logic [3:0] OP_AND = 4'b0110;
  localparam logic [3:0] OP_OR  = 4'b0101;
  localparam logic [3:0] OP_XOR = 4'b0100;
  localparam logic [3:0] OP_LSR = 4'b1010;
  localparam logic [3:0] OP_LSL = 4'b1001;
  localparam logic [3:0] OP_ROR = 4'b1110;
  localparam logic [3:0] OP_ROL = 4'b1101;
  localparam logic [3:0] OP_CMP = 4'b1111;
  localparam logic [3:0] OP_BIT = 4'b1000;

  typedef struct packed {
    logic alu_z;
    logic alu_c;
    logic alu_o;
    logic sh_c;
    logic zero_z;
    logic bit_z;
    logic cmp_gt;
    logic cmp_eq;
  } src_en_t;

endpackage

// File: rtl/flagu_decode.sv
module flagu_decode
  import flagu_pkg::*;
(
  input  logic [3:0] op_sel,
  input  logic       cmp_sel,
  output src_en_t    src_en
);

  always_comb begin
    src_en = '0;
    unique case (op_sel)
      OP_ADD, OP_SUB: begin
        src_en.alu_z = 1'b1;
        src_en.alu_c = 1'b1;
        src_en.alu_o = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: src_en.alu_z = 1'b1;
      OP_LSR, OP_LSL:        src_en.sh_c  = 1'b1;
      OP_CMP: begin
        if (cmp_sel) begin
          src_en.cmp_gt = 1'b1;
          src_en.cmp_eq = 1'b1;
        end else begin
          src_en.zero_z = 1'b1;
        end
      end
      OP_BIT:  src_en.bit_z = 1'b1;
      default: src_en = '0;
    endcase
  end

endmodule

// File: rtl/flagu_compare.sv
module flagu_compare #(
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] temp,
  output logic              is_zero,
  output logic              is_eq,
  output logic              is_gt,
  output logic              bit_clear
);

  logic [SEL_W-1:0] bit_idx;

  always_comb begin
    bit_idx   = temp[SEL_W-1:0];
    is_zero   = (bus_in == '0);
    is_eq     = (temp == bus_in);
    is_gt     = (temp > bus_in);
    bit_clear = ~bus_in[bit_idx];
  end

endmodule

// File: rtl/flagu_merge.sv
module flagu_merge #(
  parameter int FLAG_N = 4,
  parameter int SRC_N  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [FLAG_N-1:0][SRC_N-1:0]  src_en,
  input  logic [FLAG_N-1:0][SRC_N-1:0]  src_val,
  output logic [FLAG_N-1:0]             flags
);

  logic [FLAG_N-1:0] nxt;

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    logic upd;
    logic val;
    assign upd    = |src_en[f];
    assign val    = |(src_en[f] & src_val[f]);
    assign nxt[f] = upd ? val : flags[f];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags <= '0;
    else if (load) flags <= nxt;
  end

endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flagu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_sel,
  input  logic              cmp_sel,
  input  logic              flag_load,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] temp,
  input  logic              alu_zero,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              shift_carry,
  input  logic              flag_out_en,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_out_en
);

  src_en_t           en;
  logic              is_zero, is_eq, is_gt, bit_clear;
  logic [FLAG_N-1:0] flags_q;
  logic [FLAG_N-1:0][SRC_N-1:0] m_en, m_val;

  flagu_decode i_dec (
    .op_sel  (op_sel),
    .cmp_sel (cmp_sel),
    .src_en  (en)
  );

  flagu_compare #(.DATA_W(DATA_W)) i_cmp (
    .bus_in    (bus_in),
    .temp      (temp),
    .is_zero   (is_zero),
    .is_eq     (is_eq),
    .is_gt     (is_gt),
    .bit_clear (bit_clear)
  );

  always_comb begin
    m_en  = '0;
    m_val = '0;
    m_en[FZ]  = {en.bit_z, en.zero_z, en.alu_z};
    m_val[FZ] = {bit_clear, is_zero, alu_zero};
    m_en[FC]  = {1'b0, en.sh_c, en.alu_c};
    m_val[FC] = {1'b0, shift_carry, alu_carry};
    m_en[FO]  = {1'b0, en.cmp_gt, en.alu_o};
    m_val[FO] = {1'b0, is_gt, alu_ovf};
    m_en[FE]  = {2'b00, en.cmp_eq};
    m_val[FE] = {2'b00, is_eq};
  end

  flagu_merge #(.FLAG_N(FLAG_N), .SRC_N(SRC_N)) i_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (flag_load),
    .src_en  (m_en),
    .src_val (m_val),
    .flags   (flags_q)
  );

  always_comb begin
    bus_out_en = flag_out_en;
    bus_out    = '0;
    if (flag_out_en) bus_out[FLAG_N-1:0] = flags_q;
  end

endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
  import flagu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_sel,
  input logic              cmp_sel,
  input logic              flag_load,
  input logic [DATA_W-1:0] bus_in,
  input logic [DATA_W-1:0] temp,
  input logic              alu_zero,
  input logic              alu_carry,
  input logic              alu_ovf,
  input logic              shift_carry,
  input logic              flag_out_en,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_out_en,
  input logic [FLAG_N-1:0] flags
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_load |=> $stable(flags));

  p_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && op_sel == OP_CMP && cmp_sel) |=>
      (flags[FE] == $past(bus_in == temp)) && (flags[FO] == $past(temp > bus_in))
      && (flags[FZ] == $past(flags[FZ])) && (flags[FC] == $past(flags[FC])));

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && op_sel == OP_CMP && !cmp_sel) |=>
      (flags[FZ] == $past(bus_in == '0)) && (flags[3:1] == $past(flags[3:1])));

  p_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && op_sel == OP_BIT) |=>
      (flags[FZ] == !$past(bus_in[temp[SEL_W-1:0]])) && (flags[3:1] == $past(flags[3:1])));

  p_arith_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && (op_sel == OP_ADD || op_sel == OP_SUB)) |=>
      (flags[2:0] == $past({alu_ovf, alu_carry, alu_zero})) && $stable(flags[FE]));

  p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && (op_sel == OP_LSR || op_sel == OP_LSL)) |=>
      (flags[FC] == $past(shift_carry)) && $stable(flags[FZ]) && $stable(flags[3:2]));

  p_rot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_ROR || op_sel == OP_ROL) |=> $stable(flags));

  p_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_out_en |-> bus_out_en && (bus_out[FLAG_N-1:0] == flags)
                    && (bus_out[DATA_W-1:FLAG_N] == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_out_en |-> !bus_out_en && (bus_out == '0));

endmodule

bind flag_unit flag_unit_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .cmp_sel(cmp_sel),
  .flag_load(flag_load), .bus_in(bus_in), .temp(temp),
  .alu_zero(alu_zero), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
  .shift_carry(shift_carry), .flag_out_en(flag_out_en),
  .bus_out(bus_out), .bus_out_en(bus_out_en), .flags(flags_q)
);

// File: tb/test_flag_unit.sv
`timescale 1ns/1ps
module test_flag_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_sel = '0;
  logic       cmp_sel = 1'b0, flag_load = 1'b0;
  logic [7:0] bus_in = '0, temp = '0;
  logic       alu_zero = 1'b0, alu_carry = 1'b0, alu_ovf = 1'b0, shift_carry = 1'b0;
  logic       flag_out_en = 1'b0;
  logic [7:0] bus_out;
  logic       bus_out_en;

  int checks = 0, fails = 0;
  logic [3:0] model = '0;   // bit0 Z, bit1 C, bit2 O, bit3 E

  always #2.5 clk = ~clk;

  flag_unit i_flag_unit (.*);

  function automatic string req_of(input logic [3:0] op, input logic cs, input logic ld);
    if (!ld) return "R2";
    case (op)
      4'b1111: return cs ? "R3" : "R4";
      4'b1000: return "R5";
      4'b0011, 4'b0010: return "R6";
      4'b0110, 4'b0101, 4'b0100: return "R7";
      4'b1010, 4'b1001: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [3:0] next_flags(
    input logic [3:0] f, input logic [3:0] op, input logic cs, input logic ld,
    input logic [7:0] b, input logic [7:0] t,
    input logic az, input logic ac, input logic ao, input logic sc);
    logic [3:0] n;
    n = f;
    if (ld) begin
      case (op)
        4'b1111: if (cs) begin n[3] = (b == t); n[2] = (t > b); end
                 else n[0] = (b == 8'd0);
        4'b1000: n[0] = ~b[t[2:0]];
        4'b0011, 4'b0010: begin n[0] = az; n[1] = ac; n[2] = ao; end
        4'b0110, 4'b0101, 4'b0100: n[0] = az;
        4'b1010, 4'b1001: n[1] = sc;
        default: ;
      endcase
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic cs, input logic ld,
                      input logic [7:0] b, input logic [7:0] t,
                      input logic az, input logic ac, input logic ao,
                      input logic sc, input logic oe);
    @(negedge clk);
    op_sel = op; cmp_sel = cs; flag_load = ld; bus_in = b; temp = t;
    alu_zero = az; alu_carry = ac; alu_ovf = ao; shift_carry = sc; flag_out_en = oe;
    @(posedge clk);
    #1;
    model = next_flags(model, op, cs, ld, b, t, az, ac, ao, sc);
    if (oe) check({req_of(op, cs, ld), "/R10"}, {bus_out_en, bus_out}, {1'b1, 4'b0, model});
    else    check("R10 idle", {bus_out_en, bus_out}, 9'd0);
  endtask

  // read flags without loading
  task automatic peek(input string req);
    @(negedge clk);
    flag_load = 1'b0; flag_out_en = 1'b1;
    #1;
    check(req, {bus_out_en, bus_out}, {1'b1, 4'b0, model});
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset idle", {bus_out_en, bus_out}, 9'd0);
    flag_out_en = 1'b1;
    #1;
    check("R1 reset flags", {bus_out_en, bus_out}, 9'h100);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    step(4'b0011, 0, 1, 8'h00, 8'h00, 1, 1, 1, 1, 1);   // R6 set Z C O
    step(4'b1111, 1, 1, 8'h00, 8'hFF, 0, 0, 0, 0, 1);   // R3 temp max > bus 0
    step(4'b1111, 1, 1, 8'hFF, 8'h00, 1, 1, 1, 1, 1);   // R3 temp < bus
    step(4'b1111, 1, 1, 8'h5A, 8'h5A, 0, 0, 0, 0, 1);   // R3 equal
    step(4'b1111, 1, 1, 8'h80, 8'h7F, 0, 0, 0, 0, 1);   // R3 unsigned, not signed
    step(4'b1111, 0, 1, 8'h00, 8'h33, 0, 0, 0, 0, 1);   // R4 zero
    step(4'b1111, 0, 1, 8'h01, 8'h00, 1, 1, 1, 1, 1);   // R4 nonzero
    step(4'b1000, 0, 1, 8'h7F, 8'hF7, 0, 0, 0, 0, 1);   // R5 bit 7 clear, upper temp ignored
    step(4'b1000, 0, 1, 8'h01, 8'hF8, 1, 1, 1, 1, 1);   // R5 bit 0 set
    step(4'b0110, 0, 1, 8'h00, 8'h00, 1, 0, 0, 1, 1);   // R7 only Z
    step(4'b1001, 0, 1, 8'h00, 8'h00, 0, 1, 1, 1, 1);   // R8 only C
    step(4'b1110, 1, 1, 8'h00, 8'h00, 0, 0, 0, 0, 1);   // R9 rotate
    step(4'b0000, 0, 1, 8'h00, 8'h00, 1, 1, 1, 1, 1);   // R9 unlisted
    step(4'b1111, 1, 0, 8'h11, 8'h22, 1, 1, 1, 1, 0);   // R2 hold, R10 idle
    peek("R2 hold readback");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic [7:0] b, t;
      op = 4'($urandom);
      if (($urandom % 4) == 0) op = 4'b1111;
      b  = 8'($urandom);
      t  = (($urandom % 5) == 0) ? b : 8'($urandom);
      if (($urandom % 8) == 0) b = 8'h00;
      step(op, 1'($urandom), (($urandom % 6) != 0), b, t,
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           (($urandom % 5) != 0));
      if (!flag_out_en) peek({req_of(op, cmp_sel, flag_load), " readback"});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule